// File: doc/BRIEF.md
# Priority-Masked Interrupt Acceptance Controller

This block decides, once per instruction boundary, whether one of several peripheral interrupt requests is taken. Each source presents a request flag, an enable flag, a 3-bit level and a service-mode bit. Among the eligible sources the block picks the most urgent one. It compares that source's level against the current level mask, and takes the request only when the level is strictly more urgent. A taken request either becomes a CPU interrupt entry or is handed to a transfer-service engine through a start/complete handshake.

On a CPU entry the block pushes the old level mask and stack-select flag onto a 4-entry save stack. It then loads the source's level into the mask, sets the stack-select flag and presents the source index as the vector number. A return pulse pops the saved state. A source routed to the transfer engine interrupts the CPU only once the engine reports that its count is exhausted or that the peripheral asked for completion.

The controller is a two-state machine. ST_ARB is the arbitration state, and its transitions are: stay in ST_ARB on a return, on no acceptance or on a CPU entry; move to ST_SERVICE when a request whose service-mode bit is set is taken. ST_SERVICE waits for the engine, and its transitions are: stay while no completion is signalled; move back to ST_ARB on completion, performing the CPU entry in that same step.

Top module: `intacc_ctrl`

## Requirements
- R1: A source is eligible only when the global enable, its request flag and its enable flag are all 1; with any of them 0 that source is never taken.
- R2: An eligible request is taken only when the level mask is numerically greater than the request's level (0 is most urgent, 7 can never be taken); an equal level is refused.
- R3: A CPU entry gives a one-cycle accept pulse with route 0 (CPU), the source index on the vector output, the request's level in the mask and the stack-select flag set to 1.
- R4: Among eligible sources the lowest level value wins; among equal levels the lowest source index wins.
- R5: When the winning source's service-mode bit is 1, the accept pulse carries route 1 (transfer) and a one-cycle transfer start pulse appears with the source index; the mask, stack-select flag and save stack are left unchanged.
- R6: While a transfer is outstanding no new request is taken and returns are ignored; the first cycle with count-done or completion-request high produces a CPU entry (as in R3) for the transferred source with the level it had when it was taken, without a new mask comparison.
- R7: While the software-interrupt-in-progress input is 1, no hardware request is taken.
- R8: Requests are evaluated only on cycles with the step strobe high (issued at each instruction boundary and at each step of a string operation); outputs change at the clock edge that samples the strobe.
- R9: A return pulse in the arbitration state pops the save stack and restores the mask and stack-select flag; a return and a step strobe in the same cycle perform only the return.
- R10: A return with an empty save stack, or a CPU entry with the stack already holding 4 entries, sets a sticky error flag; the empty pop changes nothing else, and the full push stores nothing but the entry still happens.
- R11: Reset leaves the mask at 7, the stack-select flag at 0, the save stack empty, the error flag at 0 and no accept or start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Instruction-boundary / string-step strobe |
| sw_int_i | input | 1 | Software interrupt instruction in progress |
| gie_i | input | 1 | Global interrupt enable |
| req_i | input | N_SRC | Per-source request flags |
| en_i | input | N_SRC | Per-source enable flags |
| mode_i | input | N_SRC | Per-source transfer-service mode bits |
| lvl_i | input | N_SRC*3 | Per-source level, source k in bits [3k+2:3k] |
| ret_i | input | 1 | Return-from-interrupt pulse |
| xfer_cnt_done_i | input | 1 | Transfer engine reached its programmed count |
| xfer_cplt_i | input | 1 | Peripheral requested transfer completion |
| accept_o | output | 1 | One-cycle acceptance pulse |
| route_o | output | 1 | Route of last acceptance: 0 CPU, 1 transfer |
| vec_o | output | IDX_W | Source index of last acceptance |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| xfer_src_o | output | IDX_W | Source handed to the transfer engine |
| ilm_o | output | 3 | Current level mask |
| stk_sel_o | output | 1 | Stack-select flag (1 = system stack) |
| stk_err_o | output | 1 | Sticky save-stack error |

## Verification
Directed patterns isolate each acceptance gate: the global and per-source enables one at a time, a request at the same level as the mask versus one level more urgent, two equal-level sources against a more urgent higher-index source, and the software-interrupt and missing-strobe blocks. Transfer-mode sources are closed once by count-done and once by completion request, while a more urgent request arrives mid-service to show it is held off. A nested entry and return chain, ending in a pop of the empty stack, separates correct restore order from a plain reset of the mask. Long random runs mix all inputs so that overflowing nests, returns colliding with strobes and completions during service are compared cycle by cycle against a bench model.

// File: rtl/intacc_pkg.sv
package intacc_pkg;
    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t mask;
        logic sstk;
    } save_t;

    typedef enum logic {
        ST_ARB     = 1'b0,
        ST_SERVICE = 1'b1
    } state_t;

    typedef enum logic {
        RT_CPU  = 1'b0,
        RT_XFER = 1'b1
    } route_t;
endpackage

// File: rtl/intacc_arbiter.sv
module intacc_arbiter
    import intacc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   gie_i,
    input  logic [N_SRC-1:0]       req_i,
    input  logic [N_SRC-1:0]       en_i,
    input  logic [N_SRC-1:0]       mode_i,
    input  logic [N_SRC*LVL_W-1:0] lvl_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o,
    output lvl_t                   lvl_o,
    output logic                   mode_o
);
    logic [N_SRC-1:0] elig;
    lvl_t             lvls [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign elig[g] = gie_i & req_i[g] & en_i[g];
        assign lvls[g] = lvl_i[g*LVL_W +: LVL_W];
    end

    // Strict less-than keeps the lowest index among equal levels.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        lvl_o  = '1;
        mode_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!hit_o || (lvls[i] < lvl_o))) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                lvl_o  = lvls[i];
                mode_o = mode_i[i];
            end
        end
    end
endmodule

// File: rtl/intacc_save_stack.sv
module intacc_save_stack
    import intacc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  logic  pop_i,
    input  save_t din_i,
    output save_t top_o,
    output logic  empty_o,
    output logic  full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    save_t            mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_ptr;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign top_ptr = cnt_q - 1'b1;
    assign top_o   = empty_o ? '0 : mem[top_ptr[PTR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push_i && !full_o) begin
            mem[cnt_q[PTR_W-1:0]] <= din_i;
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/intacc_ctrl.sv
module intacc_ctrl
    import intacc_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int STK_DEPTH = 4,
    parameter int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_i,
    input  logic                   sw_int_i,
    input  logic                   gie_i,
    input  logic [N_SRC-1:0]       req_i,
    input  logic [N_SRC-1:0]       en_i,
    input  logic [N_SRC-1:0]       mode_i,
    input  logic [N_SRC*LVL_W-1:0] lvl_i,
    input  logic                   ret_i,
    input  logic                   xfer_cnt_done_i,
    input  logic                   xfer_cplt_i,
    output logic                   accept_o,
    output logic                   route_o,
    output logic [IDX_W-1:0]       vec_o,
    output logic                   xfer_start_o,
    output logic [IDX_W-1:0]       xfer_src_o,
    output logic [LVL_W-1:0]       ilm_o,
    output logic                   stk_sel_o,
    output logic                   stk_err_o
);
    state_t           state_q, state_d;
    logic             hit, win_mode;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic [IDX_W-1:0] pend_idx_q, entry_idx;
    lvl_t             pend_lvl_q, entry_lvl, ilm_q;
    logic             sstk_q, err_q;
    logic             take, xfer_done;
    logic             cpu_entry, xfer_go, ret_req;
    logic             stk_empty, stk_full;
    save_t            stk_top, stk_din;

    intacc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .gie_i  (gie_i),
        .req_i  (req_i),
        .en_i   (en_i),
        .mode_i (mode_i),
        .lvl_i  (lvl_i),
        .hit_o  (hit),
        .idx_o  (win_idx),
        .lvl_o  (win_lvl),
        .mode_o (win_mode)
    );

    assign stk_din = '{mask: ilm_q, sstk: sstk_q};

    intacc_save_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (cpu_entry),
        .pop_i   (ret_req),
        .din_i   (stk_din),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    assign take      = step_i && !sw_int_i && hit && (ilm_q > win_lvl);
    assign xfer_done = xfer_cnt_done_i || xfer_cplt_i;

    // Next state and the decisions for this cycle.
    always_comb begin
        state_d   = state_q;
        cpu_entry = 1'b0;
        xfer_go   = 1'b0;
        ret_req   = 1'b0;
        entry_idx = win_idx;
        entry_lvl = win_lvl;
        unique case (state_q)
            ST_ARB: begin
                if (ret_i) begin
                    ret_req = 1'b1;
                end else if (take) begin
                    if (win_mode) begin
                        xfer_go = 1'b1;
                        state_d = ST_SERVICE;
                    end else begin
                        cpu_entry = 1'b1;
                    end
                end
            end
            ST_SERVICE: begin
                entry_idx = pend_idx_q;
                entry_lvl = pend_lvl_q;
                if (xfer_done) begin
                    cpu_entry = 1'b1;
                    state_d   = ST_ARB;
                end
            end
            default: state_d = ST_ARB;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARB;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and held context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_o     <= 1'b0;
            route_o      <= RT_CPU;
            vec_o        <= '0;
            xfer_start_o <= 1'b0;
            xfer_src_o   <= '0;
            pend_idx_q   <= '0;
            pend_lvl_q   <= '0;
            ilm_q        <= '1;
            sstk_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            accept_o     <= cpu_entry || xfer_go;
            xfer_start_o <= xfer_go;
            if (cpu_entry) begin
                route_o <= RT_CPU;
                vec_o   <= entry_idx;
                ilm_q   <= entry_lvl;
                sstk_q  <= 1'b1;
                if (stk_full) begin
                    err_q <= 1'b1;
                end
            end
            if (xfer_go) begin
                route_o    <= RT_XFER;
                vec_o      <= win_idx;
                xfer_src_o <= win_idx;
                pend_idx_q <= win_idx;
                pend_lvl_q <= win_lvl;
            end
            if (ret_req) begin
                if (stk_empty) begin
                    err_q <= 1'b1;
                end else begin
                    ilm_q  <= stk_top.mask;
                    sstk_q <= stk_top.sstk;
                end
            end
        end
    end

    assign ilm_o     = ilm_q;
    assign stk_sel_o = sstk_q;
    assign stk_err_o = err_q;
endmodule

// File: rtl/intacc_checker.sv
module intacc_checker
    import intacc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       step_i,
    input logic       sw_int_i,
    input logic       xfer_cnt_done_i,
    input logic       xfer_cplt_i,
    input logic       accept_o,
    input logic       route_o,
    input logic       xfer_start_o,
    input logic [2:0] ilm_o,
    input logic       stk_sel_o,
    input logic       stk_err_o,
    input state_t     state_q
);
    AST_ENTRY_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ($past(step_i) || $past(xfer_cnt_done_i || xfer_cplt_i))); // R8

    AST_SW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_ARB && sw_int_i) |-> !accept_o); // R7

    AST_CPU_SETS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && route_o == RT_CPU) |-> stk_sel_o); // R3

    AST_MASK_TIGHTENS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && route_o == RT_CPU) |-> (ilm_o < $past(ilm_o))); // R2

    AST_XFER_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && route_o == RT_XFER) |-> (xfer_start_o && ilm_o == $past(ilm_o))); // R5

    AST_START_IS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> (accept_o && route_o == RT_XFER)); // R5

    AST_SERVICE_ENDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_SERVICE && (xfer_cnt_done_i || xfer_cplt_i))
            |-> (accept_o && route_o == RT_CPU)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stk_err_o) |-> stk_err_o); // R10
endmodule

bind intacc_ctrl intacc_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .step_i          (step_i),
    .sw_int_i        (sw_int_i),
    .xfer_cnt_done_i (xfer_cnt_done_i),
    .xfer_cplt_i     (xfer_cplt_i),
    .accept_o        (accept_o),
    .route_o         (route_o),
    .xfer_start_o    (xfer_start_o),
    .ilm_o           (ilm_o),
    .stk_sel_o       (stk_sel_o),
    .stk_err_o       (stk_err_o),
    .state_q         (state_q)
);

// File: tb/tb_intacc_ctrl.sv
`timescale 1ns/1ps
module tb_intacc_ctrl;
    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0, sw_int_i = 1'b0, gie_i = 1'b0;
    logic [N-1:0]  req_i = '0, en_i = '0, mode_i = '0;
    logic [N*3-1:0] lvl_i = '1;
    logic          ret_i = 1'b0, xfer_cnt_done_i = 1'b0, xfer_cplt_i = 1'b0;
    logic          accept_o, route_o, xfer_start_o, stk_sel_o, stk_err_o;
    logic [IW-1:0] vec_o, xfer_src_o;
    logic [2:0]    ilm_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Bench model state
    int m_ilm, m_s, m_err, m_busy, m_pidx, m_plvl;
    int m_acc, m_route, m_vec, m_xs, m_xsrc, m_cnt;
    int stk_ilm [DEPTH];
    int stk_s   [DEPTH];

    intacc_ctrl #(.N_SRC(N), .STK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .sw_int_i(sw_int_i),
        .gie_i(gie_i), .req_i(req_i), .en_i(en_i), .mode_i(mode_i),
        .lvl_i(lvl_i), .ret_i(ret_i), .xfer_cnt_done_i(xfer_cnt_done_i),
        .xfer_cplt_i(xfer_cplt_i), .accept_o(accept_o), .route_o(route_o),
        .vec_o(vec_o), .xfer_start_o(xfer_start_o), .xfer_src_o(xfer_src_o),
        .ilm_o(ilm_o), .stk_sel_o(stk_sel_o), .stk_err_o(stk_err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(int k);
        return int'(lvl_i[k*3 +: 3]);
    endfunction

    task automatic set_lvl(int k, int v);
        lvl_i[k*3 +: 3] = 3'(v);
    endtask

    task automatic model_reset();
        m_ilm = 7; m_s = 0; m_err = 0; m_busy = 0; m_pidx = 0; m_plvl = 0;
        m_acc = 0; m_route = 0; m_vec = 0; m_xs = 0; m_xsrc = 0; m_cnt = 0;
    endtask

    task automatic model_push();
        if (m_cnt == DEPTH) m_err = 1;
        else begin
            stk_ilm[m_cnt] = m_ilm;
            stk_s[m_cnt]   = m_s;
            m_cnt++;
        end
    endtask

    task automatic model_eval();
        int bl, bi;
        m_acc = 0; m_xs = 0;
        if (m_busy != 0) begin
            if (xfer_cnt_done_i || xfer_cplt_i) begin
                m_acc = 1; m_route = 0; m_vec = m_pidx;
                model_push();
                m_ilm = m_plvl; m_s = 1; m_busy = 0;
            end
        end else if (ret_i) begin
            if (m_cnt == 0) m_err = 1;
            else begin
                m_cnt--;
                m_ilm = stk_ilm[m_cnt];
                m_s   = stk_s[m_cnt];
            end
        end else if (step_i && !sw_int_i && gie_i) begin
            bl = 8; bi = 0;
            for (int k = 0; k < N; k++) begin
                if (req_i[k] && en_i[k] && lvl_of(k) < bl) begin
                    bl = lvl_of(k); bi = k;
                end
            end
            if (bl < 8 && m_ilm > bl) begin
                m_acc = 1; m_vec = bi;
                if (mode_i[bi]) begin
                    m_route = 1; m_xs = 1; m_xsrc = bi;
                    m_busy = 1; m_pidx = bi; m_plvl = bl;
                end else begin
                    m_route = 0;
                    model_push();
                    m_ilm = bl; m_s = 1;
                end
            end
        end
    endtask

    task automatic compare_all();
        chk("R2 accept", int'(accept_o), m_acc);
        chk("R5 route", int'(route_o), m_route);
        chk("R4 vector", int'(vec_o), m_vec);
        chk("R5 xfer_start", int'(xfer_start_o), m_xs);
        chk("R5 xfer_src", int'(xfer_src_o), m_xsrc);
        chk("R3 mask", int'(ilm_o), m_ilm);
        chk("R9 stack_sel", int'(stk_sel_o), m_s);
        chk("R10 error", int'(stk_err_o), m_err);
    endtask

    task automatic cyc();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clr();
        step_i = 0; sw_int_i = 0; gie_i = 1; req_i = '0; en_i = '1;
        mode_i = '0; lvl_i = '1; ret_i = 0; xfer_cnt_done_i = 0; xfer_cplt_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        clr();
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 mask", int'(ilm_o), 7);
        chk("R11 stack_sel", int'(stk_sel_o), 0);
        chk("R11 error", int'(stk_err_o), 0);
        chk("R11 accept", int'(accept_o), 0);

        // R1 eligibility
        clr(); gie_i = 0; step_i = 1; req_i[1] = 1; set_lvl(1, 2); cyc();
        chk("R1 global enable low", int'(accept_o), 0);
        gie_i = 1; en_i[1] = 0; cyc();
        chk("R1 source enable low", int'(accept_o), 0);
        en_i[1] = 1; cyc();
        chk("R3 entry accept", int'(accept_o), 1);
        chk("R3 entry vector", int'(vec_o), 1);
        chk("R3 entry mask", int'(ilm_o), 2);
        chk("R3 entry stack_sel", int'(stk_sel_o), 1);

        // R2 strict comparison
        clr(); step_i = 1; req_i[3] = 1; set_lvl(3, 2); cyc();
        chk("R2 equal level refused", int'(accept_o), 0);
        set_lvl(3, 1); cyc();
        chk("R2 more urgent taken", int'(accept_o), 1);
        chk("R2 mask now", int'(ilm_o), 1);

        // R4 tie on level: lower index wins
        clr(); step_i = 1; req_i[2] = 1; req_i[5] = 1; set_lvl(2, 0); set_lvl(5, 0); cyc();
        chk("R4 tie vector", int'(vec_o), 2);

        // R9 nested returns
        clr(); ret_i = 1; cyc();
        chk("R9 pop mask", int'(ilm_o), 1);
        cyc();
        chk("R9 pop mask", int'(ilm_o), 2);
        cyc();
        chk("R9 pop mask", int'(ilm_o), 7);
        chk("R9 pop stack_sel", int'(stk_sel_o), 0);
        cyc();
        chk("R10 empty pop error", int'(stk_err_o), 1);
        chk("R10 empty pop mask", int'(ilm_o), 7);

        // R4 level beats index
        clr(); step_i = 1; req_i[1] = 1; set_lvl(1, 3); req_i[6] = 1; set_lvl(6, 1); cyc();
        chk("R4 urgent higher index", int'(vec_o), 6);

        // R9 return beats strobe
        clr(); step_i = 1; ret_i = 1; req_i[0] = 1; set_lvl(0, 0); cyc();
        chk("R9 return precedence accept", int'(accept_o), 0);
        chk("R9 return precedence mask", int'(ilm_o), 7);

        // R7 software interrupt blocks
        clr(); step_i = 1; sw_int_i = 1; req_i[0] = 1; set_lvl(0, 0); cyc();
        chk("R7 blocked", int'(accept_o), 0);

        // R8 no strobe
        clr(); req_i[0] = 1; set_lvl(0, 0); cyc();
        chk("R8 no strobe", int'(accept_o), 0);
        step_i = 1; cyc();
        chk("R8 strobe taken", int'(accept_o), 1);
        clr(); ret_i = 1; cyc();

        // R5 / R6 transfer route closed by count
        clr(); step_i = 1; mode_i[4] = 1; req_i[4] = 1; set_lvl(4, 3); cyc();
        chk("R5 route transfer", int'(route_o), 1);
        chk("R5 start pulse", int'(xfer_start_o), 1);
        chk("R5 start source", int'(xfer_src_o), 4);
        chk("R5 mask unchanged", int'(ilm_o), 7);
        clr(); step_i = 1; req_i[0] = 1; set_lvl(0, 0); ret_i = 1; cyc();
        chk("R6 held off in service", int'(accept_o), 0);
        clr(); xfer_cnt_done_i = 1; cyc();
        chk("R6 count done entry", int'(accept_o), 1);
        chk("R6 count done route", int'(route_o), 0);
        chk("R6 count done vector", int'(vec_o), 4);
        chk("R6 count done mask", int'(ilm_o), 3);
        clr(); ret_i = 1; cyc();

        // R6 closed by completion request
        clr(); step_i = 1; mode_i[7] = 1; req_i[7] = 1; set_lvl(7, 5); cyc();
        clr(); cyc();
        xfer_cplt_i = 1; cyc();
        chk("R6 completion entry", int'(accept_o), 1);
        chk("R6 completion mask", int'(ilm_o), 5);
        clr(); ret_i = 1; cyc();

        // Random phase
        void'($urandom(32'd20240611));
        for (int pass = 0; pass < 2; pass++) begin
            do_reset();
            for (int n = 0; n < 3000; n++) begin
                req_i = N'($urandom);
                en_i = N'($urandom | $urandom);
                mode_i = N'($urandom & $urandom & $urandom);
                lvl_i = (N*3)'($urandom);
                step_i = ($urandom % 2) == 0;
                sw_int_i = ($urandom % 8) == 0;
                gie_i = ($urandom % 8) != 0;
                ret_i = ($urandom % 5) == 0;
                xfer_cnt_done_i = ($urandom % 5) == 0;
                xfer_cplt_i = ($urandom % 7) == 0;
                cyc();
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule